// File: doc/BRIEF.md
# Host Reset Sequencing Controller

This block produces the three reset outputs a host complex needs: a hard reset for the processor, a soft reset request for the processor (INIT), and a reset for the peripheral bus. Its inputs are an asynchronous power-good level, a single I/O-mapped reset control register, and a pulse that marks a shutdown bus cycle. All outputs are registered state of the host clock, so they change only on its rising edge.

When power-good rises, two timed windows start together. The peripheral-bus reset ends after one millisecond. The processor hard reset ends after two milliseconds, and only once an "init done" input reports that internal initialization has finished. The millisecond is set by a parameter that gives host clocks per millisecond. After that, software controls resets through the register. Writing the request bit from 0 to 1 starts either the same two-millisecond hard reset or a short INIT pulse, depending on the enable bit. A shutdown cycle also raises INIT.

Top module: `host_reset_seq`

## Requirements
- R1: Power-good is passed through two flops. A change on `pwr_good_async` before rising edge 1 first changes the outputs at edge 3: when power-good drops, `pbus_rst` is still 0 after edge 2 and is 1 after edge 3.
- R2: While the synchronized power-good is low, `pbus_rst` and `cpu_hard_rst` are 1 and `cpu_init` is 0.
- R3: After power-good rises (first sampled at edge 1), `pbus_rst` is 1 after edge 2+M and 0 after edge 3+M, where M = `CYC_PER_MS`.
- R4: After power-good rises, `cpu_hard_rst` is 1 after edge 2+2M and 0 after edge 3+2M, provided `init_done` is 1. While `init_done` is 0 the hard reset stays asserted. It is released on the first edge that samples `init_done` high once the 2M window has run out.
- R5: The control register answers only at address 0x0CF9, written when `io_wr` is 1. Bit 1 is the hard-reset enable and bit 2 is the reset request. `io_rdata` shows these two bits in the same positions, and all other bits read 0. A write to any other address changes nothing.
- R6: With enable=1, a write that moves the request bit from 0 to 1 (write sampled at edge W) raises `cpu_hard_rst` after edge W+1 for exactly 2M cycles. `pbus_rst` stays 0.
- R7: With enable=0, such a write raises `cpu_init` after edge W+1 for exactly `INIT_CYC` cycles, and `cpu_hard_rst` stays 0.
- R8: Writing 1 to the request bit when it already holds 1 starts no reset.
- R9: A `shutdown_cyc` pulse sampled at edge S raises `cpu_init` after S for exactly `INIT_CYC` cycles (at least 2).
- R10: Writes made during a software hard-reset pulse are stored and read back, but they neither restart nor lengthen the pulse.
- R11: Both register bits clear to 0 while the synchronized power-good is low, and writes in that time are ignored.
- R12: While `rst_n` is 0 at a clock edge: `cpu_hard_rst`=1, `pbus_rst`=1, `cpu_init`=0 and `io_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good_async | input | 1 | Power-good level, asynchronous |
| init_done | input | 1 | Internal initialization finished |
| shutdown_cyc | input | 1 | One-cycle shutdown bus-cycle indication |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Register read-back |
| cpu_hard_rst | output | 1 | Processor hard reset, active high |
| cpu_init | output | 1 | Processor soft reset (INIT), active high |
| pbus_rst | output | 1 | Peripheral-bus reset, active high |

## Verification
The bench builds the block with `CYC_PER_MS`=20 and `INIT_CYC`=3. With these values the one- and two-millisecond windows last 20 and 40 cycles, so every window boundary can be checked at the exact edge on both sides. A power cycle with `init_done` held low, a hard reset with writes made during it, and back-to-back INIT triggers all fit within a few hundred cycles. An `INIT_CYC` above the minimum of 2 also shows that the INIT length comes from the parameter and not from a fixed pair of flops.

// File: rtl/hrs_pkg.sv
// Shared types for the host reset sequencer.
// Assumes nothing beyond the enum encoding being private to the block.
package hrs_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,  // power-good low: everything held in reset
        ST_PWRUP  = 2'd1,  // timed release after power-good
        ST_RUN    = 2'd2,  // normal operation
        ST_SWHARD = 2'd3   // software-requested hard reset pulse
    } seq_state_e;
endpackage

// File: rtl/hrs_pg_sync.sv
// Two-flop synchronizer for the asynchronous power-good level.
// Assumes the input is a slow level; a glitch shorter than a clock may be lost.
module hrs_pg_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;

    // Shift the async level through two host-clock flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/hrs_ms_timer.sv
// Saturating window timer measured in host clocks.
// Restarts from zero on clr; flags one and two millisecond points.
// Assumes CYC_PER_MS >= 1.
module hrs_ms_timer #(
    parameter int CYC_PER_MS = 66000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic one_ms,
    output logic two_ms
);
    localparam int TWO_MS = 2 * CYC_PER_MS;
    localparam int CW     = $clog2(TWO_MS + 1);
    localparam logic [CW-1:0] LAST = CW'(TWO_MS - 1);
    localparam logic [CW-1:0] HALF = CW'(CYC_PER_MS);

    logic [CW-1:0] cnt_q;

    // Count up from zero after clr and hold at the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign one_ms = (cnt_q >= HALF);
    assign two_ms = (cnt_q == LAST);

    // R4: the window counter never runs past its final value
    a_r4_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/hrs_ctrl_reg.sv
// I/O-mapped reset control register with 0-to-1 edge detection on the
// request bit. Emits a one-cycle hard or soft request pulse per edge.
// Assumes a single-cycle write strobe; clr holds the register at zero.
module hrs_ctrl_reg #(
    parameter logic [15:0] REG_ADDR = 16'h0CF9,
    parameter int          DW       = 8,
    parameter int          HEN_BIT  = 1,
    parameter int          REQ_BIT  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          io_wr,
    input  logic [15:0]   io_addr,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic          hard_req,
    output logic          soft_req
);
    logic hen_q;
    logic req_q;
    logic hit;

    assign hit = io_wr && (io_addr == REG_ADDR);

    // Store the two control bits and flag a fresh rising request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hen_q    <= 1'b0;
            req_q    <= 1'b0;
            hard_req <= 1'b0;
            soft_req <= 1'b0;
        end else begin
            hard_req <= 1'b0;
            soft_req <= 1'b0;
            if (hit) begin
                hen_q <= io_wdata[HEN_BIT];
                req_q <= io_wdata[REQ_BIT];
                if (io_wdata[REQ_BIT] && !req_q) begin
                    hard_req <= io_wdata[HEN_BIT];
                    soft_req <= !io_wdata[HEN_BIT];
                end
            end
        end
    end

    // Present the stored bits at their write positions.
    always_comb begin
        io_rdata          = '0;
        io_rdata[HEN_BIT] = hen_q;
        io_rdata[REQ_BIT] = req_q;
    end

    // R6 / R7: a request edge yields exactly one kind of reset
    a_r7_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(hard_req && soft_req));
    // R11: power loss leaves the register empty
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (io_rdata == '0));
endmodule

// File: rtl/host_reset_seq.sv
// Host reset sequencer: drives processor hard reset, processor INIT and
// peripheral-bus reset from power-good, a control register and shutdown.
// Assumes init_done is synchronous to clk; CYC_PER_MS and INIT_CYC >= 2.
module host_reset_seq
    import hrs_pkg::*;
#(
    parameter int          CYC_PER_MS = 66000,
    parameter int          INIT_CYC   = 2,
    parameter logic [15:0] REG_ADDR   = 16'h0CF9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_good_async,
    input  logic        init_done,
    input  logic        shutdown_cyc,
    input  logic        io_wr,
    input  logic [15:0] io_addr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic        cpu_hard_rst,
    output logic        cpu_init,
    output logic        pbus_rst
);
    localparam int IW = $clog2(INIT_CYC + 1);

    seq_state_e    state_q;
    logic          pg_s;
    logic          one_ms;
    logic          two_ms;
    logic          tmr_clr;
    logic          hard_req;
    logic          soft_req;
    logic [IW-1:0] init_cnt_q;

    hrs_pg_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pwr_good_async),
        .sync_out (pg_s)
    );

    hrs_ms_timer #(.CYC_PER_MS(CYC_PER_MS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .one_ms (one_ms),
        .two_ms (two_ms)
    );

    hrs_ctrl_reg #(.REG_ADDR(REG_ADDR), .DW(8)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!pg_s),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .hard_req (hard_req),
        .soft_req (soft_req)
    );

    // Restart the window on power-up entry and on an accepted hard request.
    assign tmr_clr = (state_q == ST_OFF) || ((state_q == ST_RUN) && hard_req);

    // Sequence power-up, normal running and software hard resets.
    always_ff @(posedge clk) begin
        if (!rst_n || !pg_s) begin
            state_q <= ST_OFF;
        end else begin
            case (state_q)
                ST_OFF:    state_q <= ST_PWRUP;
                ST_PWRUP:  if (two_ms && init_done) state_q <= ST_RUN;
                ST_RUN:    if (hard_req) state_q <= ST_SWHARD;
                ST_SWHARD: if (two_ms) state_q <= ST_RUN;
                default:   state_q <= ST_OFF;
            endcase
        end
    end

    // Time the INIT pulse from a soft request or a shutdown cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !pg_s) begin
            init_cnt_q <= '0;
        end else if ((state_q == ST_RUN) && (soft_req || shutdown_cyc)) begin
            init_cnt_q <= IW'(INIT_CYC);
        end else if (init_cnt_q != '0) begin
            init_cnt_q <= init_cnt_q - 1'b1;
        end
    end

    assign cpu_hard_rst = (state_q != ST_RUN);
    assign pbus_rst     = (state_q == ST_OFF) || ((state_q == ST_PWRUP) && !one_ms);
    assign cpu_init     = (init_cnt_q != '0);

    // R2: peripheral reset follows a low synchronized power-good
    a_r2_pbus_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_s |=> pbus_rst);
    // R4: hard reset is already active when power-good comes up
    a_r4_hard_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_s) |=> cpu_hard_rst);
    // R3: the peripheral bus is out of reset before the processor leaves it
    a_r3_pbus_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_hard_rst) |-> !pbus_rst);
    // R9: INIT lasts at least two host clocks
    a_r9_init_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_init) |=> cpu_init);
endmodule

// File: tb/host_reset_seq_tb_top.sv
`timescale 1ns/1ps
module host_reset_seq_tb_top;
    localparam int MS = 20;
    localparam int IC = 3;
    localparam logic [15:0] RA = 16'h0CF9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg = 1'b0;
    logic        init_done = 1'b1;
    logic        shutdown_cyc = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cpu_hard_rst, cpu_init, pbus_rst;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // scoreboard queue: cycle, signal id (0 hard, 1 init, 2 pbus, 3 rdata), value, tag
    int    q_at[$];
    int    q_sig[$];
    int    q_val[$];
    string q_tag[$];

    always #2.5 clk = ~clk;

    host_reset_seq #(.CYC_PER_MS(MS), .INIT_CYC(IC), .REG_ADDR(RA)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_good_async(pg), .init_done(init_done),
        .shutdown_cyc(shutdown_cyc), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_hard_rst(cpu_hard_rst),
        .cpu_init(cpu_init), .pbus_rst(pbus_rst)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sig_val(int s);
        case (s)
            0: return int'(cpu_hard_rst);
            1: return int'(cpu_init);
            2: return int'(pbus_rst);
            default: return int'(io_rdata);
        endcase
    endfunction

    function automatic string sig_name(int s);
        case (s)
            0: return "cpu_hard_rst";
            1: return "cpu_init";
            2: return "pbus_rst";
            default: return "io_rdata";
        endcase
    endfunction

    task automatic chk(int s, int exp, string tag);
        total++;
        if (sig_val(s) != exp) begin
            bad++;
            $display("FAIL %s cyc=%0d %s actual=%0h expected=%0h", tag, cyc, sig_name(s), sig_val(s), exp);
        end
    endtask

    // driver side: expect value v on signal s, k edges from now
    task automatic expect_at(int k, int s, int v, string tag);
        q_at.push_back(cyc + k);
        q_sig.push_back(s);
        q_val.push_back(v);
        q_tag.push_back(tag);
    endtask

    // monitor: compare due items between edges
    always @(negedge clk) begin
        for (int i = q_at.size() - 1; i >= 0; i--) begin
            if (q_at[i] == cyc) begin
                chk(q_sig[i], q_val[i], q_tag[i]);
                q_at.delete(i);
                q_sig.delete(i);
                q_val.delete(i);
                q_tag.delete(i);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic io_write(logic [15:0] a, logic [7:0] d);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        step(4);
        // R12: reset values
        chk(0, 1, "R12"); chk(1, 0, "R12"); chk(2, 1, "R12"); chk(3, 0, "R12");
        rst_n = 1'b1;
        step(4);
        // R2: power-good still low
        chk(0, 1, "R2"); chk(2, 1, "R2"); chk(1, 0, "R2");

        // R3 / R4: power-up sequence
        pg = 1'b1;
        expect_at(2 + MS, 2, 1, "R3");
        expect_at(3 + MS, 2, 0, "R3");
        expect_at(2 + 2*MS, 0, 1, "R4");
        expect_at(3 + 2*MS, 0, 0, "R4");
        step(2*MS + 6);

        // R5: wrong address ignored, right address stores enable
        io_write(16'h0CFA, 8'h06);
        chk(3, 0, "R5"); chk(0, 0, "R5");
        io_write(RA, 8'h02);
        chk(3, 8'h02, "R5");
        step(2);
        chk(0, 0, "R5");

        // R6: hard reset by software, R10: writes during it
        expect_at(1, 0, 0, "R6");
        expect_at(2, 0, 1, "R6");
        expect_at(1 + 2*MS, 0, 1, "R10");
        expect_at(2 + 2*MS, 0, 0, "R10");
        expect_at(2 + MS, 2, 0, "R6");
        io_write(RA, 8'h06);
        step(3);
        io_write(RA, 8'h02);
        io_write(RA, 8'h06);
        chk(3, 8'h06, "R10");
        step(2*MS + 4);

        // R8: repeated 1 does not retrigger
        expect_at(2, 0, 0, "R8");
        expect_at(3, 0, 0, "R8");
        expect_at(3, 1, 0, "R8");
        io_write(RA, 8'h06);
        step(5);

        // R7: soft reset via INIT
        io_write(RA, 8'h00);
        chk(3, 0, "R5");
        expect_at(1, 1, 0, "R7");
        expect_at(2, 1, 1, "R7");
        expect_at(1 + IC, 1, 1, "R7");
        expect_at(2 + IC, 1, 0, "R7");
        expect_at(2, 0, 0, "R7");
        io_write(RA, 8'h04);
        step(IC + 4);

        // R9: shutdown cycle
        expect_at(1, 1, 1, "R9");
        expect_at(IC, 1, 1, "R9");
        expect_at(1 + IC, 1, 0, "R9");
        shutdown_cyc = 1'b1;
        step(1);
        shutdown_cyc = 1'b0;
        step(IC + 3);

        // R1 / R11: power loss
        init_done = 1'b0;
        pg = 1'b0;
        expect_at(2, 2, 0, "R1");
        expect_at(3, 2, 1, "R1");
        expect_at(3, 0, 1, "R2");
        expect_at(3, 3, 0, "R11");
        step(5);
        io_write(RA, 8'h06);
        chk(3, 0, "R11");
        step(2);

        // R4: release waits for init_done
        pg = 1'b1;
        expect_at(3 + MS, 2, 0, "R3");
        expect_at(3 + 2*MS + 4, 0, 1, "R4");
        step(3 + 2*MS + 6);
        init_done = 1'b1;
        expect_at(1, 0, 0, "R4");
        step(4);

        done = 1'b1;
        if (q_at.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard pending=%0d expected=0", q_at.size());
        end
        summary();
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog cyc=%0d expected completion", cyc);
            summary();
            $finish;
        end
    end
endmodule